// File: doc/BRIEF.md
# Atomic-Alias Control and Status Register Bank

This block is the software-visible register file of a four-channel coprocessor. It holds a global control register, a global status register, a channel control register, and four registers for each channel: pointer, semaphore, status and options. Each register answers at four consecutive word offsets. Software can replace a register, OR bits into it, clear bits in it or invert bits in it with a single store. It never has to read, modify and write back.

The control register drives the soft-reset and clock-gate outputs. While soft reset is held, every other register is pinned to its reset value. The datapath, which is not part of this block, reports completions with one-cycle pulses per channel. Each pulse latches a status flag. A single interrupt line is raised whenever a latched flag meets its enable bit. The bus is a simple port: reads are combinational in the same cycle, and writes take effect at the next rising clock edge.

Top module: `copro_regbank`

## Requirements
- R1: Byte-address bits 3:2 choose how a write acts on the addressed register. 0 replaces the register with the write data. 1 ORs the data in. 2 clears every bit that is 1 in the data. 3 XORs the data in. Address bits 1:0 are ignored.
- R2: The control register is at 0x000. Bits 31, 30, 23, 22, 21 and 3:0 are writable. Bits 29 and 28 always read as 1. All other bits read as 0 and ignore writes. Bit 31 drives `soft_rst` and bit 30 drives `clk_gate`.
- R3: The status register is at 0x010. Bits 3:0 are the channel interrupt flags. Bits 19:16 show `ready_mask`, bits 27:24 show `cur_chan` and bit 28 shows `key_ready`. All other bits read as 0.
- R4: A one-cycle pulse on `ch_irq_set[n]` sets status flag n. The only way to clear a flag is a write at 0x018 with data bit n set. Writes at 0x010, 0x014 and 0x01C leave the flags unchanged. If a set pulse and a clear of the same flag happen in one cycle, the flag ends up set.
- R5: `irq` is high exactly when some status flag n and control enable bit n are both 1.
- R6: The channel control register is at 0x020. Bits 3:0 (channel enables), 11:8 (high-priority flags) and 16 (channel 0 interrupt merge) are writable. All other bits read as 0.
- R7: Channel n has four registers, each at base + n×0x40: pointer at 0x100, semaphore at 0x110, status at 0x120 and options at 0x130. Pointer, status and options are 32 bits wide. The semaphore keeps only bits 7:0.
- R8: While control bit 31 is 1, every register except the control register holds its reset value. Writes and set pulses to those registers have no effect. The bit stays set until software clears it.
- R9: Reads at any of a register's four alias offsets return its value in the same cycle. Reads at unmapped offsets return 0, and writes there change nothing. `bus_rdata` is 0 when no read is requested.
- R10: After `rst_n` goes low, the control register reads 0x7000_0000, so clock gate is set and soft reset is clear. Every other register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ch_irq_set | input | 4 | Per-channel one-cycle interrupt set pulses |
| ready_mask | input | 4 | Ready-channel mask shown in status |
| cur_chan | input | 4 | Current channel number shown in status |
| key_ready | input | 1 | Key-ready flag shown in status |
| soft_rst | output | 1 | Soft reset, control bit 31 |
| clk_gate | output | 1 | Clock gate, control bit 30 |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that every input is synchronous to `clk` and holds known values after reset. They also assume that `ch_irq_set` carries single-cycle pulses, so that a flag falling without a clear-alias write can only be a design error. The bench changes all inputs on the falling edge. It asserts each set pulse for exactly one cycle, and it holds `bus_sel` low between accesses, so a write acts at exactly one rising edge.

// File: rtl/copro_regbank.sv
module copro_regbank #(
  parameter int NCH = 4,
  parameter int AW  = 12,
  parameter int DW  = 32,
  parameter int SEMA_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic [NCH-1:0] ch_irq_set,
  input  logic [3:0]    ready_mask,
  input  logic [3:0]    cur_chan,
  input  logic          key_ready,
  output logic          soft_rst,
  output logic          clk_gate,
  output logic          irq
);
  localparam int SW = AW - 4;
  localparam logic [DW-1:0] EN_M    = DW'((1 << NCH) - 1);
  localparam logic [DW-1:0] CTRL_WM = DW'(32'hC0E0_0000) | EN_M;
  localparam logic [DW-1:0] CTRL_RO = DW'(32'h3000_0000);
  localparam logic [DW-1:0] CTRL_RV = DW'(32'h4000_0000);
  localparam logic [DW-1:0] CCTL_WM = DW'(32'h0001_0000) | (EN_M << 8) | EN_M;
  localparam logic [DW-1:0] SEMA_M  = DW'((1 << SEMA_W) - 1);

  function automatic logic [DW-1:0] apply(input logic [DW-1:0] old, input logic [DW-1:0] wd,
                                          input logic [1:0] op);
    case (op)
      2'd0: apply = wd;
      2'd1: apply = old | wd;
      2'd2: apply = old & ~wd;
      default: apply = old ^ wd;
    endcase
  endfunction

  logic          wr, rd;
  logic [1:0]    op;
  logic [SW-1:0] slot;
  logic [1:0]    ch_idx, ch_reg;
  logic          hit_ctrl, hit_stat, hit_cctl, hit_chan, hit_any;
  logic          unused_addr_lo;

  assign wr   = bus_sel & bus_we;
  assign rd   = bus_sel & ~bus_we;
  assign op   = bus_addr[3:2];
  assign slot = bus_addr[AW-1:4];
  assign ch_idx = slot[3:2];
  assign ch_reg = slot[1:0];
  assign unused_addr_lo = ^bus_addr[1:0];

  assign hit_ctrl = slot == SW'(0);
  assign hit_stat = slot == SW'(1);
  assign hit_cctl = slot == SW'(2);
  assign hit_chan = (slot[SW-1:4] == (SW-4)'(1)) && (int'(ch_idx) < NCH);
  assign hit_any  = hit_ctrl | hit_stat | hit_cctl | hit_chan;

  logic [DW-1:0]  ctrl_q, cctl_q;
  logic [NCH-1:0] flags_q, flag_clr;
  logic [DW-1:0]  ch_ptr [NCH];
  logic [DW-1:0]  ch_sema[NCH];
  logic [DW-1:0]  ch_stat[NCH];
  logic [DW-1:0]  ch_opt [NCH];

  assign soft_rst = ctrl_q[31];
  assign clk_gate = ctrl_q[30];
  assign irq      = |(flags_q & ctrl_q[NCH-1:0]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 ctrl_q <= CTRL_RV;
    else if (wr && hit_ctrl)    ctrl_q <= apply(ctrl_q, bus_wdata, op) & CTRL_WM;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 cctl_q <= '0;
    else if (soft_rst)          cctl_q <= '0;
    else if (wr && hit_cctl)    cctl_q <= apply(cctl_q, bus_wdata, op) & CCTL_WM;

  assign flag_clr = (wr && hit_stat && op == 2'd2) ? bus_wdata[NCH-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        flags_q <= '0;
    else if (soft_rst) flags_q <= '0;
    else               flags_q <= (flags_q & ~flag_clr) | ch_irq_set;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic sel_c;
    assign sel_c = wr && hit_chan && (ch_idx == 2'(c));
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n || soft_rst) begin
        ch_ptr[c]  <= '0;
        ch_sema[c] <= '0;
        ch_stat[c] <= '0;
        ch_opt[c]  <= '0;
      end else if (sel_c) begin
        case (ch_reg)
          2'd0: ch_ptr[c]  <= apply(ch_ptr[c],  bus_wdata, op);
          2'd1: ch_sema[c] <= apply(ch_sema[c], bus_wdata, op) & SEMA_M;
          2'd2: ch_stat[c] <= apply(ch_stat[c], bus_wdata, op);
          default: ch_opt[c] <= apply(ch_opt[c], bus_wdata, op);
        endcase
      end
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit_ctrl) bus_rdata = ctrl_q | CTRL_RO;
      else if (hit_stat) begin
        bus_rdata[NCH-1:0] = flags_q;
        bus_rdata[19:16]   = ready_mask;
        bus_rdata[27:24]   = cur_chan;
        bus_rdata[28]      = key_ready;
      end
      else if (hit_cctl) bus_rdata = cctl_q;
      else if (hit_chan) begin
        case (ch_reg)
          2'd0: bus_rdata = ch_ptr[ch_idx];
          2'd1: bus_rdata = ch_sema[ch_idx];
          2'd2: bus_rdata = ch_stat[ch_idx];
          default: bus_rdata = ch_opt[ch_idx];
        endcase
      end
    end
  end

  p_present_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && hit_ctrl) |-> bus_rdata[29:28] == 2'b11);

  p_set_latches_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && ch_irq_set != '0) |=> ((flags_q & $past(ch_irq_set)) == $past(ch_irq_set)));

  p_no_drop_without_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!soft_rst && !(wr && hit_stat && op == 2'd2)) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  p_irq_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[NCH-1:0] == '0) |-> !irq);

  p_srst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (cctl_q == '0 && flags_q == '0 && ch_ptr[0] == '0));

  p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd || !hit_any) |-> bus_rdata == '0);
endmodule

// File: tb/copro_regbank_tb_top.sv
module copro_regbank_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  ch_irq_set = '0, ready_mask = '0, cur_chan = '0;
  logic        key_ready = 0;
  logic        soft_rst, clk_gate, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  copro_regbank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_irq_set(ch_irq_set), .ready_mask(ready_mask), .cur_chan(cur_chan),
    .key_ready(key_ready), .soft_rst(soft_rst), .clk_gate(clk_gate), .irq(irq));

  // {we, addr, wdata, expected read}
  localparam int NV = 39;
  localparam logic [76:0] VEC [NV] = '{
    {1'b0, 12'h000, 32'h0, 32'h7000_0000},       // R10 reset value
    {1'b1, 12'h000, 32'h0, 32'h0},               // R1 plain
    {1'b0, 12'h000, 32'h0, 32'h3000_0000},       // R2
    {1'b1, 12'h004, 32'hFFFF_FFFF, 32'h0},       // R1 set
    {1'b0, 12'h000, 32'h0, 32'hF0E0_000F},       // R2 mask
    {1'b1, 12'h008, 32'h8000_0000, 32'h0},       // R1 clear
    {1'b0, 12'h000, 32'h0, 32'h70E0_000F},
    {1'b1, 12'h00C, 32'h4000_0005, 32'h0},       // R1 toggle
    {1'b0, 12'h000, 32'h0, 32'h30E0_000A},
    {1'b1, 12'h000, 32'h0FFF_FFF0, 32'h0},
    {1'b0, 12'h000, 32'h0, 32'h30E0_0000},       // R2 read-only ignored
    {1'b1, 12'h020, 32'hFFFF_FFFF, 32'h0},       // R6
    {1'b0, 12'h020, 32'h0, 32'h0001_0F0F},
    {1'b1, 12'h028, 32'h0000_0101, 32'h0},
    {1'b0, 12'h020, 32'h0, 32'h0001_0E0E},
    {1'b1, 12'h02C, 32'h0001_0003, 32'h0},
    {1'b0, 12'h020, 32'h0, 32'h0000_0E0D},
    {1'b1, 12'h024, 32'h0000_0010, 32'h0},
    {1'b0, 12'h020, 32'h0, 32'h0000_0E0D},
    {1'b1, 12'h100, 32'h1234_5678, 32'h0},       // R7 ch0 pointer
    {1'b1, 12'h104, 32'h8000_0001, 32'h0},
    {1'b0, 12'h100, 32'h0, 32'h9234_5679},
    {1'b1, 12'h1C0, 32'hFFFF_0000, 32'h0},       // R7 ch3 pointer
    {1'b1, 12'h1C8, 32'h0F0F_0000, 32'h0},
    {1'b0, 12'h1C0, 32'h0, 32'hF0F0_0000},
    {1'b1, 12'h150, 32'hABCD_EF12, 32'h0},       // R7 ch1 semaphore width
    {1'b0, 12'h150, 32'h0, 32'h0000_0012},
    {1'b1, 12'h1A0, 32'hDEAD_BEEF, 32'h0},       // R7 ch2 status
    {1'b1, 12'h1AC, 32'hFFFF_FFFF, 32'h0},
    {1'b0, 12'h1A0, 32'h0, 32'h2152_4110},
    {1'b1, 12'h130, 32'h55AA_55AA, 32'h0},       // R9 read at alias
    {1'b0, 12'h13C, 32'h0, 32'h55AA_55AA},
    {1'b0, 12'h140, 32'h0, 32'h0},               // R7 neighbour untouched
    {1'b1, 12'h030, 32'hFFFF_FFFF, 32'h0},       // R9 unmapped
    {1'b0, 12'h030, 32'h0, 32'h0},
    {1'b0, 12'h200, 32'h0, 32'h0},
    {1'b0, 12'h0F0, 32'h0, 32'h0},
    {1'b1, 12'h010, 32'h0000_000F, 32'h0},       // R4 plain write ignored
    {1'b0, 12'h010, 32'h0, 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    #1;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1;
    chk(req, bus_rdata, exp);
    bus_sel = 0;
  endtask

  task automatic pulse(input logic [3:0] s);
    @(negedge clk);
    ch_irq_set = s;
    @(negedge clk);
    ch_irq_set = '0;
    #1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R10 soft_rst", {31'b0, soft_rst}, 32'h0);
    chk("R10 clk_gate", {31'b0, clk_gate}, 32'h1);
    chk("R10 irq", {31'b0, irq}, 32'h0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][76]) wr(VEC[i][75:64], VEC[i][63:32]);
      else rd_chk($sformatf("R1/R2/R6/R7/R9 vector %0d", i), VEC[i][75:64], VEC[i][31:0]);
    end

    // R3 read-only status fields
    ready_mask = 4'hA; cur_chan = 4'h3; key_ready = 1;
    rd_chk("R3 status fields", 12'h010, 32'h130A_0000);

    // R4 / R5 flags and interrupt
    pulse(4'b0101);
    rd_chk("R4 flags set", 12'h010, 32'h130A_0005);
    chk("R5 irq masked", {31'b0, irq}, 32'h0);
    wr(12'h004, 32'h0000_0004);
    chk("R5 irq enabled", {31'b0, irq}, 32'h1);
    wr(12'h018, 32'h0000_0004);
    chk("R5 irq after clear", {31'b0, irq}, 32'h0);
    wr(12'h010, 32'h0);
    wr(12'h014, 32'hF);
    wr(12'h01C, 32'hF);
    rd_chk("R4 only clear alias acts", 12'h010, 32'h130A_0001);

    // R4 set wins over simultaneous clear
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = 12'h018; bus_wdata = 32'h3; ch_irq_set = 4'b0010;
    @(negedge clk);
    bus_sel = 0; bus_we = 0; ch_irq_set = '0;
    rd_chk("R4 set wins", 12'h010, 32'h130A_0002);
    wr(12'h004, 32'h0000_0002);
    chk("R5 irq on flag1", {31'b0, irq}, 32'h1);

    // R8 soft reset
    wr(12'h004, 32'h8000_0000);
    @(negedge clk); #1;
    chk("R8 soft_rst out", {31'b0, soft_rst}, 32'h1);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);
    rd_chk("R8 cctl held", 12'h020, 32'h0);
    rd_chk("R8 ch0 ptr held", 12'h100, 32'h0);
    rd_chk("R8 ch2 stat held", 12'h1A0, 32'h0);
    wr(12'h020, 32'h0000_000F);
    rd_chk("R8 write ignored", 12'h020, 32'h0);
    pulse(4'hF);
    rd_chk("R8 pulse ignored", 12'h010, 32'h130A_0000);
    repeat (5) @(negedge clk);
    #1;
    chk("R8 not self clearing", {31'b0, soft_rst}, 32'h1);
    wr(12'h008, 32'h8000_0000);
    chk("R8 released", {31'b0, soft_rst}, 32'h0);
    rd_chk("R8 ctrl kept", 12'h000, 32'h30E0_0006);
    wr(12'h004, 32'h4000_0000);
    chk("R2 clk_gate out", {31'b0, clk_gate}, 32'h1);

    // R9 no read request
    #1;
    chk("R9 idle rdata", bus_rdata, 32'h0);

    // R10 hardware reset mid-run
    wr(12'h100, 32'hCAFE_0001);
    @(negedge clk);
    rst_n = 0;
    rd_chk("R10 ctrl after reset", 12'h000, 32'h7000_0000);
    rd_chk("R10 ch0 ptr after reset", 12'h100, 32'h0);
    chk("R10 soft_rst after reset", {31'b0, soft_rst}, 32'h0);
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule